// File: doc/BRIEF.md
# Edge-Triggered Phase-Frequency Comparator

This block is the error detector of a digital phase-locked loop. It watches two single-bit inputs, a reference signal and a feedback signal from the loop's divider, on a fast system clock. Only their rising edges matter. From the order of those edges it decides whether the loop's oscillator is behind, and must be pushed up, or ahead, and must be pushed down. When neither is true it leaves the loop filter undriven so that its voltage holds.

Both inputs pass through a synchroniser chain of configurable depth and then a rising-edge detector. The edge pulses drive a three-state machine: hold, pump-up or pump-down. The state is decoded into separate up and down enables, a resolved three-state pair (a data bit plus an output enable) and a lock flag. The lock flag is high exactly while the detector holds. Falling edges and duty cycle do not affect the outputs. If the reference has no edges while the feedback keeps toggling, the detector keeps pumping down and pulls the oscillator to its lowest frequency.

Top module: `edge_phase_freq_det`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge) the detector holds: `up_o`=0, `dn_o`=0, `tri_en_o`=0, `tri_bit_o`=0, `lock_o`=1.
- R2: A rising edge on `sig_in` while the detector holds sets `up_o`=1. With SYNC_STAGES=2 the output changes at the third rising clock edge at or after which `sig_in` is sampled high.
- R3: A rising edge on `cmp_in` while the detector holds sets `dn_o`=1, with the same latency as R2.
- R4: A rising edge on `cmp_in` alone during pump-up returns the detector to hold. A rising edge on `sig_in` alone during pump-down also returns it to hold. Pulse width therefore equals the edge spacing.
- R5: Further `sig_in` rising edges during pump-up, with no `cmp_in` edge, keep `up_o` high continuously.
- R6: Further `cmp_in` rising edges during pump-down, with no `sig_in` edge, keep `dn_o` high continuously.
- R7: Falling edges and static levels on either input leave every output unchanged.
- R8: Rising edges on both inputs detected in the same clock cycle cancel, and the next state is hold, from any state.
- R9: `up_o` and `dn_o` are never both 1. `tri_en_o` = `up_o` | `dn_o`, and `tri_bit_o` = 1 for pump-up and 0 otherwise.
- R10: `lock_o` is 1 exactly when `tri_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_in | input | 1 | Reference signal, asynchronous |
| cmp_in | input | 1 | Feedback comparator signal, asynchronous |
| up_o | output | 1 | Pump-up enable |
| dn_o | output | 1 | Pump-down enable |
| tri_bit_o | output | 1 | Resolved three-state data bit (1 = up) |
| tri_en_o | output | 1 | Three-state output enable |
| lock_o | output | 1 | Phase-pulse flag, high while holding |

## Verification
A wrong state shows directly on the enables, because every output is decoded from the state register. A missed transition therefore appears SYNC_STAGES+1 clock edges after the offending input edge. An edge detector that also fires on falling edges shows up as a spurious return to hold, or a spurious start of pumping, after an input falls. Cancellation and the continuous up or down cases only show after an edge sequence, so the bench walks whole sequences and checks every output a fixed settling time after each input change.

// File: rtl/epfd_pkg.sv
package epfd_pkg;

    typedef enum logic [1:0] {
        PD_HOLD = 2'b00,
        PD_UP   = 2'b01,
        PD_DN   = 2'b10
    } pd_state_e;

    typedef struct packed {
        logic up;
        logic dn;
        logic oe;
        logic bit_v;
        logic lock;
    } pd_drive_t;

    localparam int unsigned PD_INPUTS = 2;
    localparam int unsigned IDX_SIG   = 0;
    localparam int unsigned IDX_CMP   = 1;

    function automatic pd_state_e pd_next(input pd_state_e st,
                                          input logic sig_r,
                                          input logic cmp_r);
        pd_state_e nx;
        nx = st;
        unique case ({sig_r, cmp_r})
            2'b11:   nx = PD_HOLD;
            2'b10:   nx = (st == PD_DN) ? PD_HOLD : PD_UP;
            2'b01:   nx = (st == PD_UP) ? PD_HOLD : PD_DN;
            default: nx = st;
        endcase
        return nx;
    endfunction

    function automatic pd_drive_t pd_decode(input pd_state_e st);
        pd_drive_t d;
        d.up    = (st == PD_UP);
        d.dn    = (st == PD_DN);
        d.oe    = d.up | d.dn;
        d.bit_v = d.up;
        d.lock  = ~d.oe;
        return d;
    endfunction

endpackage

// File: rtl/epfd_edge_sync.sv
module epfd_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= din;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= 1'b0;
            else     chain[g] <= chain[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain[LAST];
    end

    assign rise_o = chain[LAST] & ~prev_q;

endmodule

// File: rtl/epfd_fsm.sv
module epfd_fsm
    import epfd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sig_rise,
    input  logic      cmp_rise,
    output pd_state_e state_o
);
    pd_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= PD_HOLD;
        else     state_q <= pd_next(state_q, sig_rise, cmp_rise);
    end

    assign state_o = state_q;

endmodule

// File: rtl/epfd_drive.sv
module epfd_drive
    import epfd_pkg::*;
(
    input  pd_state_e state_i,
    output pd_drive_t drive_o
);
    always_comb begin
        drive_o = pd_decode(state_i);
    end

endmodule

// File: rtl/edge_phase_freq_det.sv
module edge_phase_freq_det
    import epfd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    input  logic cmp_in,
    output logic up_o,
    output logic dn_o,
    output logic tri_bit_o,
    output logic tri_en_o,
    output logic lock_o
);
    logic [PD_INPUTS-1:0] raw_vec;
    logic [PD_INPUTS-1:0] rise_vec;
    pd_state_e            state;
    pd_drive_t            drv;

    assign raw_vec[IDX_SIG] = sig_in;
    assign raw_vec[IDX_CMP] = cmp_in;

    for (genvar i = 0; i < PD_INPUTS; i++) begin : g_in
        epfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst    (rst),
            .din    (raw_vec[i]),
            .rise_o (rise_vec[i])
        );
    end

    epfd_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .sig_rise (rise_vec[IDX_SIG]),
        .cmp_rise (rise_vec[IDX_CMP]),
        .state_o  (state)
    );

    epfd_drive u_drive (
        .state_i (state),
        .drive_o (drv)
    );

    assign up_o      = drv.up;
    assign dn_o      = drv.dn;
    assign tri_bit_o = drv.bit_v;
    assign tri_en_o  = drv.oe;
    assign lock_o    = drv.lock;

endmodule

// File: rtl/epfd_chk.sv
module epfd_chk (
    input logic clk,
    input logic rst,
    input logic sig_r,
    input logic cmp_r,
    input logic up,
    input logic dn,
    input logic tbit,
    input logic oe,
    input logic lock
);
    assert_reset_hold_R1: assert property (@(posedge clk)
        rst |=> (lock && !up && !dn && !oe));

    assert_start_up_R2: assert property (@(posedge clk) disable iff (rst)
        (lock && sig_r && !cmp_r) |=> up);

    assert_start_dn_R3: assert property (@(posedge clk) disable iff (rst)
        (lock && cmp_r && !sig_r) |=> dn);

    assert_up_ends_R4: assert property (@(posedge clk) disable iff (rst)
        (up && cmp_r && !sig_r) |=> lock);

    assert_dn_ends_R4: assert property (@(posedge clk) disable iff (rst)
        (dn && sig_r && !cmp_r) |=> lock);

    assert_up_stays_R5: assert property (@(posedge clk) disable iff (rst)
        (up && sig_r && !cmp_r) |=> up);

    assert_dn_stays_R6: assert property (@(posedge clk) disable iff (rst)
        (dn && cmp_r && !sig_r) |=> dn);

    assert_no_edge_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (!sig_r && !cmp_r) |=> ($stable(up) && $stable(dn)));

    assert_cancel_R8: assert property (@(posedge clk) disable iff (rst)
        (sig_r && cmp_r) |=> lock);

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({up, dn}));

    assert_tri_bit_R9: assert property (@(posedge clk) disable iff (rst)
        (oe && tbit) |-> up);

    assert_lock_R10: assert property (@(posedge clk) disable iff (rst)
        lock != oe);

endmodule

bind edge_phase_freq_det epfd_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .sig_r (rise_vec[0]),
    .cmp_r (rise_vec[1]),
    .up    (up_o),
    .dn    (dn_o),
    .tbit  (tri_bit_o),
    .oe    (tri_en_o),
    .lock  (lock_o)
);

// File: tb/edge_phase_freq_det_tb.sv
module edge_phase_freq_det_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 4;
    localparam int WATCHDOG   = 100000;

    typedef struct packed {
        logic sig;
        logic cmp;
        logic e_up;
        logic e_dn;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0},  // R1 idle after reset
        '{1'b1, 1'b0, 1'b1, 1'b0},  // R2 sig edge -> up
        '{1'b0, 1'b0, 1'b1, 1'b0},  // R7 sig fall ignored
        '{1'b0, 1'b1, 1'b0, 1'b0},  // R4 cmp edge ends up
        '{1'b0, 1'b0, 1'b0, 1'b0},  // R7 cmp fall ignored
        '{1'b0, 1'b1, 1'b0, 1'b1},  // R3 cmp edge -> down
        '{1'b0, 1'b0, 1'b0, 1'b1},  // R7
        '{1'b1, 1'b0, 1'b0, 1'b0},  // R4 sig edge ends down
        '{1'b0, 1'b0, 1'b0, 1'b0},  // R7
        '{1'b1, 1'b0, 1'b1, 1'b0},  // R2
        '{1'b0, 1'b0, 1'b1, 1'b0},  // R7
        '{1'b1, 1'b0, 1'b1, 1'b0},  // R5 second sig edge keeps up
        '{1'b0, 1'b1, 1'b0, 1'b0},  // R4
        '{1'b0, 1'b0, 1'b0, 1'b0},  // R7
        '{1'b0, 1'b1, 1'b0, 1'b1},  // R3
        '{1'b0, 1'b0, 1'b0, 1'b1},  // R7
        '{1'b0, 1'b1, 1'b0, 1'b1},  // R6 second cmp edge keeps down
        '{1'b0, 1'b0, 1'b0, 1'b1},  // R7
        '{1'b1, 1'b0, 1'b0, 1'b0}   // R4
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sig_in = 1'b0;
    logic cmp_in = 1'b0;
    logic up_o, dn_o, tri_bit_o, tri_en_o, lock_o;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_phase_freq_det u_dut (
        .clk       (clk),
        .rst       (rst),
        .sig_in    (sig_in),
        .cmp_in    (cmp_in),
        .up_o      (up_o),
        .dn_o      (dn_o),
        .tri_bit_o (tri_bit_o),
        .tri_en_o  (tri_en_o),
        .lock_o    (lock_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!done && cyc > WATCHDOG) begin
            n_run  = n_run + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual cycles %0d expected below %0d", cyc, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Compare all outputs {up,dn,oe,bit,lock} against values derived from up/dn (R9, R10)
    task automatic check(input string tag, input logic eu, input logic ed);
        logic [4:0] act, exp;
        act = {up_o, dn_o, tri_en_o, tri_bit_o, lock_o};
        exp = {eu, ed, eu | ed, eu, ~(eu | ed)};
        n_run = n_run + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual {up,dn,oe,bit,lock}=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic apply(input logic s, input logic c);
        sig_in = s;
        cmp_in = c;
        clocks(SETTLE);
    endtask

    initial begin
        clocks(3);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state", 1'b0, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].sig, VECS[i].cmp);
            check($sformatf("R2/R3/R4/R5/R6/R7 vector %0d", i), VECS[i].e_up, VECS[i].e_dn);
        end

        // R2 latency: input set at a falling edge; up appears at the third rising edge
        apply(1'b0, 1'b0);
        check("R4 back to hold before latency test", 1'b0, 1'b0);
        sig_in = 1'b1;
        clocks(2);
        check("R2 not yet after two edges", 1'b0, 1'b0);
        clocks(1);
        check("R2 up after three edges", 1'b1, 1'b0);

        // R7 long high level with no further edges: no change
        clocks(20);
        check("R7 long high level ignored", 1'b1, 1'b0);

        // R8 simultaneous edges from pump-up cancel to hold
        sig_in = 1'b0;
        cmp_in = 1'b0;
        clocks(SETTLE);
        sig_in = 1'b1;
        cmp_in = 1'b1;
        clocks(SETTLE);
        check("R8 cancel from up", 1'b0, 1'b0);

        // R8 simultaneous edges from hold stay in hold
        apply(1'b0, 1'b0);
        apply(1'b1, 1'b1);
        check("R8 cancel from hold", 1'b0, 1'b0);

        // R6 feedback toggling with quiet reference: down held continuously
        apply(1'b0, 1'b0);
        for (int j = 0; j < 4; j++) begin
            cmp_in = 1'b1;
            clocks(SETTLE);
            check("R6 down held, cmp high", 1'b0, 1'b1);
            cmp_in = 1'b0;
            clocks(SETTLE);
            check("R6 down held, cmp low", 1'b0, 1'b1);
        end

        // R1 reset during pump-down returns to hold
        rst = 1'b1;
        clocks(1);
        check("R1 reset mid-pump", 1'b0, 1'b0);
        rst = 1'b0;
        clocks(SETTLE);
        check("R1 hold after release", 1'b0, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule